// File: doc/BRIEF.md
# GPU Command Stream Packet Parser

This block takes a stream of 32-bit command words on a valid/ready input and locates the boundaries of each command packet. The command code sits in the top byte of the first word of a packet. The code decides how long the packet is. The length is either a fixed count held in a per-code ROM, or, for polylines, the position of a terminator word that is found while the words stream in. When the last word of a packet has been accepted, the parser gives a one-cycle pulse that carries the code and the word count.

Three command families also carry side effects:
- **Block transfers.** The parser emits a start event with the direction, the position word and the size word.
- **Environment settings.** These commands are copied into eight shadow registers.
- **Textured polygons.** These overwrite the low nine bits of shadow register 1 with bits taken from a word inside the packet.

The fill command has its rectangle width and height brought out as separate fields. Drawing and the movement of pixel data are left to the blocks downstream.

The parser consumes one word per cycle and never holds a partial packet back. A command whose words arrive slowly, for example a block transfer that is still waiting for its size word, simply produces nothing until its final word is in.

Top module: `gpu_cmd_parser`

## Requirements
- R1: The code of a packet is bits 31:24 of its first word. Exactly one cycle after the last word of a packet is accepted, `pkt_valid` is high for one cycle with that code on `pkt_code` and the total word count on `pkt_len`. No pulse appears in a cycle that follows a cycle without an accepted word.
- R2: For codes that are not block transfers, fills or polylines, the length comes from a per-code ROM:
  - 0x20–0x3F (polygons): 1 + n·(1+t) + s·(n−1), where n is 4 if bit 3 is set and 3 otherwise, t is bit 2 and s is bit 4.
  - 0x40–0x5F (lines): 4 if bit 4 is set, else 3.
  - 0x60–0x7F (rectangles): 2 + bit 2, plus 1 when bits 4:3 are 00.
  - 0x80–0x9F: 4.
  - Every other code: 1.
- R3: Codes 0xA0–0xDF are 3-word block transfers. With the packet pulse, `xfer_valid` pulses, `xfer_pos` holds word 1 and `xfer_size` holds word 2. `xfer_read` is 1 exactly when (code & 0xE0) = 0xC0.
- R4: A block transfer gives no packet or transfer pulse until its third word has been accepted, however many idle cycles fall between its words.
- R5: A flat polyline (codes 0x48–0x4F) ends at the first word at index 3 or above for which (word & 0xF000F000) = 0x50005000. Its length counts the terminator, so the length is the terminator index plus 1. Matching words at index 1 or 2 are treated as ordinary data.
- R6: A shaded polyline (codes 0x58–0x5F) ends only at a matching word at an even index of 4 or above. Matching words at odd indices are treated as ordinary data.
- R7: A polyline that has no terminator is closed when it reaches MAX_LEN words, and `pkt_len` is then MAX_LEN. The next word starts a new packet.
- R8: Codes 0xE0–0xE7 store their whole word into shadow register (code & 7), which is bits [32·k+31 : 32·k] of `env_regs` for register k. The change is visible one cycle after the word is accepted. On reset, register k holds (0xE0+k) << 24.
- R9: For codes 0x34–0x37 and 0x3C–0x3F, bits 8:0 of shadow register 1 are replaced by bits 8:0 of packet word 5. Bits 31:9 of register 1 and all other registers keep their values. Word 4 has no effect on them.
- R10: For fill code 0x02 (3 words), `fill_w` takes bits 9:0 of word 2 and `fill_h` takes bits 24:16 of word 2. Both are valid with the packet pulse.
- R11: `in_ready` is low during reset and high from the first clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser accepts a word |
| pkt_valid | output | 1 | One-cycle packet-complete pulse |
| pkt_code | output | 8 | Code of the completed packet |
| pkt_len | output | LEN_W | Word count of the completed packet |
| xfer_valid | output | 1 | Block-transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| fill_w | output | 10 | Width of the last fill |
| fill_h | output | 9 | Height of the last fill |
| env_regs | output | 256 | Eight shadow environment registers, concatenated |

## Verification
A corrupted word index or a stale busy flag would misplace every later boundary. The next `pkt_len` or `pkt_code` would be wrong, at the latest when the packet after the fault completes. For this reason the checks send many packet types back to back, with no idle gap between them.

A wrong kind decode in the polyline search would show up one cycle after the first terminator word that the search handles wrongly. It shows either as an early pulse at an ignored position, or as a missing pulse that later turns into a MAX_LEN close.

A faulty shadow-register path would show on `env_regs` in the cycle after the word that writes or patches the register. The bench therefore reads the registers right after each environment command and each textured polygon.

// File: rtl/gpu_cmd_pkg.sv
package gpu_cmd_pkg;

    localparam int CODE_W    = 8;
    localparam int ROM_W     = 4;
    localparam int ENV_COUNT = 8;
    localparam int PATCH_W   = 9;

    localparam logic [31:0] TERM_MASK  = 32'hF000_F000;
    localparam logic [31:0] TERM_VALUE = 32'h5000_5000;

    typedef enum logic [2:0] {
        KIND_FIXED,
        KIND_XFER,
        KIND_FILL,
        KIND_PLINE_FLAT,
        KIND_PLINE_SHADED
    } pkt_kind_e;

    function automatic pkt_kind_e kind_of(input logic [CODE_W-1:0] c);
        if (c >= 8'hA0 && c <= 8'hDF)   return KIND_XFER;
        else if (c == 8'h02)            return KIND_FILL;
        else if (c[7:3] == 5'b01001)    return KIND_PLINE_FLAT;
        else if (c[7:3] == 5'b01011)    return KIND_PLINE_SHADED;
        else                            return KIND_FIXED;
    endfunction

    // Length rule used to fill the per-code ROM
    function automatic logic [ROM_W-1:0] base_len_of(input logic [CODE_W-1:0] c);
        int n;
        int nv;
        n = 1;
        case (c[7:5])
            3'b001: begin
                nv = c[3] ? 4 : 3;
                n  = 1 + nv * (c[2] ? 2 : 1) + (c[4] ? nv - 1 : 0);
            end
            3'b010: n = c[4] ? 4 : 3;
            3'b011: n = 2 + (c[2] ? 1 : 0) + ((c[4:3] == 2'b00) ? 1 : 0);
            3'b100: n = 4;
            3'b101, 3'b110: n = 3;
            default: n = (c == 8'h02) ? 3 : 1;
        endcase
        return ROM_W'(n);
    endfunction

    function automatic logic is_tex_poly(input logic [CODE_W-1:0] c);
        return (c[7:4] == 4'h3) && c[2];
    endfunction

endpackage

// File: rtl/cmd_len_rom.sv
module cmd_len_rom
    import gpu_cmd_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = ROM_W
) (
    input  logic [CW-1:0] code,
    output logic [LW-1:0] base_len
);
    localparam int ENTRIES = 1 << CW;

    logic [LW-1:0] rom_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign rom_w[g] = LW'(base_len_of(CODE_W'(g)));
    end

    assign base_len = rom_w[code];
endmodule

// File: rtl/term_match.sv
module term_match
    import gpu_cmd_pkg::*;
(
    input  logic [31:0] word,
    output logic        hit
);
    assign hit = (word & TERM_MASK) == TERM_VALUE;
endmodule

// File: rtl/env_shadow.sv
module env_shadow
    import gpu_cmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int COUNT  = ENV_COUNT,
    parameter int PW     = PATCH_W,
    localparam int IDX_W = $clog2(COUNT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    patch_en,
    input  logic [PW-1:0]           patch_bits,
    output logic [COUNT*WORD_W-1:0] regs_flat
);
    logic [WORD_W-1:0] regs_q [COUNT];
    logic [WORD_W-1:0] regs_d [COUNT];

    always_comb begin
        regs_d = regs_q;
        if (wr_en)    regs_d[wr_idx] = wr_data;
        if (patch_en) regs_d[1][PW-1:0] = patch_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++)
                regs_q[i] <= WORD_W'(32'(224 + i) << (WORD_W - 8));
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < COUNT; g++) begin : g_flat
        assign regs_flat[g*WORD_W +: WORD_W] = regs_q[g];
    end

    // R8: registers only change on a write or a patch
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !patch_en) |=> $stable(regs_flat));

    // R9: a patch alone leaves the upper bits of register 1 untouched
    a_r9_patch_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (patch_en && !wr_en) |=> (regs_q[1][WORD_W-1:PW] == $past(regs_q[1][WORD_W-1:PW])));
endmodule

// File: rtl/gpu_cmd_parser.sv
module gpu_cmd_parser
    import gpu_cmd_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int ENV_W  = ENV_COUNT * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              pkt_valid,
    output logic [7:0]        pkt_code,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              xfer_valid,
    output logic              xfer_read,
    output logic [31:0]       xfer_pos,
    output logic [31:0]       xfer_size,
    output logic [9:0]        fill_w,
    output logic [8:0]        fill_h,
    output logic [ENV_W-1:0]  env_regs
);
    typedef struct packed {
        logic             ready;
        logic             busy;
        logic [7:0]       code;
        pkt_kind_e        kind;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] target;
        logic             pkt_valid;
        logic [7:0]       pkt_code;
        logic [LEN_W-1:0] pkt_len;
        logic             xfer_valid;
        logic             xfer_read;
        logic [31:0]      xfer_pos;
        logic [31:0]      xfer_size;
        logic [9:0]       fill_w;
        logic [8:0]       fill_h;
    } state_t;

    state_t q, d;

    logic              accept;
    logic [7:0]        in_code;
    logic [ROM_W-1:0]  rom_len;
    logic              term_hit;
    logic              fin;
    logic              env_wr;
    logic              env_patch;

    assign accept  = in_valid && q.ready;
    assign in_code = in_data[31:24];

    cmd_len_rom #(.CW(CODE_W), .LW(ROM_W)) i_len_rom (
        .code     (in_code),
        .base_len (rom_len)
    );

    term_match i_term (
        .word (in_data),
        .hit  (term_hit)
    );

    env_shadow #(.WORD_W(32), .COUNT(ENV_COUNT), .PW(PATCH_W)) i_env (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (env_wr),
        .wr_idx     (in_code[2:0]),
        .wr_data    (in_data),
        .patch_en   (env_patch),
        .patch_bits (in_data[PATCH_W-1:0]),
        .regs_flat  (env_regs)
    );

    always_comb begin
        d            = q;
        d.ready      = 1'b1;
        d.pkt_valid  = 1'b0;
        d.xfer_valid = 1'b0;
        env_wr       = 1'b0;
        env_patch    = 1'b0;
        fin          = 1'b0;
        if (accept) begin
            if (!q.busy) begin
                d.code   = in_code;
                d.kind   = kind_of(in_code);
                d.idx    = LEN_W'(1);
                d.target = LEN_W'(rom_len);
                if (in_code[7:3] == 5'b11100) env_wr = 1'b1;
                if (kind_of(in_code) == KIND_FIXED && rom_len == ROM_W'(1)) begin
                    d.pkt_valid = 1'b1;
                    d.pkt_code  = in_code;
                    d.pkt_len   = LEN_W'(1);
                end else begin
                    d.busy = 1'b1;
                end
            end else begin
                if (q.kind == KIND_XFER) begin
                    if (q.idx == LEN_W'(1)) d.xfer_pos = in_data;
                    if (q.idx == LEN_W'(2)) begin
                        d.xfer_valid = 1'b1;
                        d.xfer_size  = in_data;
                        d.xfer_read  = (q.code[7:5] == 3'b110);
                    end
                end
                if (q.kind == KIND_FILL && q.idx == LEN_W'(2)) begin
                    d.fill_w = in_data[9:0];
                    d.fill_h = in_data[24:16];
                end
                if (is_tex_poly(q.code) && q.idx == LEN_W'(4 + int'(q.code[4])))
                    env_patch = 1'b1;
                unique case (q.kind)
                    KIND_PLINE_FLAT:   fin = (q.idx >= LEN_W'(3)) && term_hit;
                    KIND_PLINE_SHADED: fin = (q.idx >= LEN_W'(4)) && !q.idx[0] && term_hit;
                    default:           fin = (q.idx == q.target - LEN_W'(1));
                endcase
                if (q.idx == LEN_W'(MAX_LEN - 1)) fin = 1'b1;
                if (fin) begin
                    d.busy      = 1'b0;
                    d.pkt_valid = 1'b1;
                    d.pkt_code  = q.code;
                    d.pkt_len   = q.idx + LEN_W'(1);
                end else begin
                    d.idx = q.idx + LEN_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready   = q.ready;
    assign pkt_valid  = q.pkt_valid;
    assign pkt_code   = q.pkt_code;
    assign pkt_len    = q.pkt_len;
    assign xfer_valid = q.xfer_valid;
    assign xfer_read  = q.xfer_read;
    assign xfer_pos   = q.xfer_pos;
    assign xfer_size  = q.xfer_size;
    assign fill_w     = q.fill_w;
    assign fill_h     = q.fill_h;

    // R1: a pulse needs a word accepted in the cycle before
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !pkt_valid);

    // R3: transfer event comes with a 3-word packet in the transfer range
    a_r3_xfer_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (pkt_valid && pkt_len == LEN_W'(3) && pkt_code >= 8'hA0 && pkt_code <= 8'hDF));

    // R3: direction follows the code
    a_r3_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_read == (pkt_code[7:5] == 3'b110)));

    // R7: lengths stay within 1..MAX_LEN
    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= LEN_W'(MAX_LEN)));

    // R5: a flat polyline has at least four words
    a_r5_flat_min: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_code[7:3] == 5'b01001) |-> (pkt_len >= LEN_W'(4)));

    // R6: a terminated shaded polyline has an odd length of five or more
    a_r6_shaded_len: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_code[7:3] == 5'b01011 && pkt_len < LEN_W'(MAX_LEN))
            |-> (pkt_len >= LEN_W'(5) && pkt_len[0]));

    // R11: ready stays high once out of reset
    a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> in_ready);
endmodule

// File: tb/test_gpu_cmd_parser.sv
module test_gpu_cmd_parser;
    localparam int MAX_LEN = 64;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              in_ready;
    logic              pkt_valid;
    logic [7:0]        pkt_code;
    logic [LEN_W-1:0]  pkt_len;
    logic              xfer_valid;
    logic              xfer_read;
    logic [31:0]       xfer_pos;
    logic [31:0]       xfer_size;
    logic [9:0]        fill_w;
    logic [8:0]        fill_h;
    logic [255:0]      env_regs;

    always #10 clk = ~clk;

    gpu_cmd_parser #(.MAX_LEN(MAX_LEN)) i_gpu_cmd_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_code(pkt_code),
        .pkt_len(pkt_len), .xfer_valid(xfer_valid), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size), .fill_w(fill_w),
        .fill_h(fill_h), .env_regs(env_regs)
    );

    typedef struct {
        logic [7:0]  code;
        int          len;
        bit          is_xfer;
        bit          rd;
        logic [31:0] pos;
        logic [31:0] size;
        bit          is_fill;
        logic [9:0]  fw;
        logic [8:0]  fh;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
        end
    endtask

    function automatic exp_t mk(input logic [7:0] c, input int l, input string t);
        exp_t e;
        e.code = c; e.len = l; e.is_xfer = 0; e.rd = 0; e.pos = '0; e.size = '0;
        e.is_fill = 0; e.fw = '0; e.fh = '0; e.tag = t;
        return e;
    endfunction

    task automatic put(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic idle_quiet(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(!pkt_valid && !xfer_valid, tag, "pulse during gap",
                  {pkt_valid, xfer_valid}, 0);
        end
    endtask

    task automatic check_env(input int k, input logic [31:0] v, input string tag);
        check(env_regs[k*32 +: 32] == v, tag, $sformatf("env%0d", k), env_regs[k*32 +: 32], v);
    endtask

    task automatic send_fixed(input logic [7:0] c, input int l, input string tag);
        exp_q.push_back(mk(c, l, tag));
        put({c, 24'h000000});
        for (int i = 1; i < l; i++) put(32'h0000_0011 * i);
    endtask

    task automatic send_xfer(input logic [7:0] c, input bit rd, input logic [31:0] p,
                             input logic [31:0] s, input string tag);
        exp_t e;
        e = mk(c, 3, tag);
        e.is_xfer = 1; e.rd = rd; e.pos = p; e.size = s;
        exp_q.push_back(e);
        put({c, 24'h0});
        put(p);
        put(s);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R1", "unexpected packet", pkt_code, 0);
            end else begin
                cur = exp_q.pop_front();
                check(pkt_code == cur.code, cur.tag, "code", pkt_code, cur.code);
                check(int'(pkt_len) == cur.len, cur.tag, "len", pkt_len, cur.len);
                if (cur.is_xfer) begin
                    check(xfer_valid == 1'b1, cur.tag, "xfer_valid", xfer_valid, 1);
                    check(xfer_read == cur.rd, cur.tag, "xfer_read", xfer_read, cur.rd);
                    check(xfer_pos == cur.pos, cur.tag, "xfer_pos", xfer_pos, cur.pos);
                    check(xfer_size == cur.size, cur.tag, "xfer_size", xfer_size, cur.size);
                end else begin
                    check(xfer_valid == 1'b0, cur.tag, "xfer_valid", xfer_valid, 0);
                end
                if (cur.is_fill) begin
                    check(fill_w == cur.fw, cur.tag, "fill_w", fill_w, cur.fw);
                    check(fill_h == cur.fh, cur.tag, "fill_h", fill_h, cur.fh);
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        exp_t e;
        // Reset state: R11, R8
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R11", "ready in reset", in_ready, 0);
        check(pkt_valid == 1'b0, "R1", "pulse in reset", pkt_valid, 0);
        for (int k = 0; k < 8; k++) check_env(k, (32'hE0 + k) << 24, "R8");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R11", "ready after reset", in_ready, 1);

        // R2: fixed lengths, back to back
        send_fixed(8'h00, 1, "R2");
        send_fixed(8'h20, 4, "R2");
        send_fixed(8'h28, 5, "R2");
        send_fixed(8'h30, 6, "R2");
        send_fixed(8'h40, 3, "R2");
        send_fixed(8'h50, 4, "R2");
        send_fixed(8'h60, 3, "R2");
        send_fixed(8'h64, 4, "R2");
        send_fixed(8'h68, 2, "R2");
        send_fixed(8'h80, 4, "R1");
        idle(2);

        // R8: environment writes
        exp_q.push_back(mk(8'hE3, 1, "R8"));
        put(32'hE312_3456);
        exp_q.push_back(mk(8'hE7, 1, "R8"));
        put(32'hE7AB_CDEF);
        exp_q.push_back(mk(8'hE1, 1, "R8"));
        put(32'hE100_0ABC);
        idle(1);
        check_env(3, 32'hE312_3456, "R8");
        check_env(7, 32'hE7AB_CDEF, "R8");
        check_env(1, 32'hE100_0ABC, "R8");

        // R9: textured shaded quad, 12 words, patch from word 5
        exp_q.push_back(mk(8'h3C, 12, "R9"));
        put(32'h3C80_8080);
        for (int i = 1; i < 12; i++) begin
            if (i == 4)      put(32'h0000_00FF);
            else if (i == 5) put(32'h0000_01A5);
            else             put(32'h0000_0022 * i);
        end
        idle(1);
        check_env(1, 32'hE100_0BA5, "R9");
        check_env(3, 32'hE312_3456, "R9");
        // textured triangle 0x34 (9 words) patches again from word 5
        exp_q.push_back(mk(8'h34, 9, "R9"));
        put(32'h3400_0000);
        for (int i = 1; i < 9; i++) put((i == 5) ? 32'h0000_0033 : 32'h0000_01FF);
        idle(1);
        check_env(1, 32'hE100_0A33, "R9");

        // R3/R4: transfer with gaps between words
        e = mk(8'hA0, 3, "R4");
        e.is_xfer = 1; e.rd = 0; e.pos = 32'h0010_0020; e.size = 32'h0008_0010;
        exp_q.push_back(e);
        put(32'hA000_0000);
        idle_quiet(3, "R4");
        put(32'h0010_0020);
        idle_quiet(2, "R4");
        put(32'h0008_0010);
        idle(1);

        // R3: directions
        send_xfer(8'hC0, 1, 32'h0004_0008, 32'h0002_0002, "R3");
        send_xfer(8'hDF, 1, 32'h0123_0456, 32'h0010_0040, "R3");
        send_xfer(8'hBF, 0, 32'h01FF_03FF, 32'h0001_0001, "R3");
        send_xfer(8'hC5, 1, 32'h0000_0000, 32'h0200_0400, "R3");

        // R10: fill
        e = mk(8'h02, 3, "R10");
        e.is_fill = 1; e.fw = 10'h140; e.fh = 9'h0F0;
        exp_q.push_back(e);
        put(32'h02FF_FFFF);
        put(32'h0020_0010);
        put(32'h00F0_0140);

        // R5: flat polyline, matches at index 1 and 2 ignored
        exp_q.push_back(mk(8'h48, 5, "R5"));
        put(32'h4811_2233);
        put(32'h5555_5555);
        put(32'h5FFF_5FFF);
        put(32'h0001_0002);
        put(32'h5000_5000);

        // R6: shaded polyline, matches at odd index ignored
        exp_q.push_back(mk(8'h5A, 7, "R6"));
        put(32'h5A00_00FF);
        put(32'h0001_0001);
        put(32'h0000_FF00);
        put(32'h5000_5000);
        put(32'h0010_0010);
        put(32'h5AAA_5BBB);
        put(32'h5000_5000);

        // R7: polyline without terminator closes at MAX_LEN
        exp_q.push_back(mk(8'h4C, MAX_LEN, "R7"));
        put(32'h4C00_0000);
        for (int i = 1; i < MAX_LEN; i++) put(32'h0000_0000);
        send_fixed(8'h01, 1, "R7");
        idle(3);

        check(exp_q.size() == 0, "R1", "missing packets", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule